// File: doc/BRIEF.md
# Two-Channel ADC Sampling Sequencer

This block is the control state machine that drives an external two-channel analog-to-digital converter from the always-on clock. It switches the converter's power on and off. For every sample pair it selects channel 0 and then channel 1, waits for the converter's data-valid strobe on each, and keeps the last result of each channel. A separate filter block judges each pair and reports back one "all filters matched" bit, which the sequencer samples on the channel-1 strobe.

Three flows exist:

- **Oneshot** takes one pair, ignores the filter verdict and raises a completion pulse.
- **Low-power** sleeps with the converter off, wakes on a programmable period, samples one pair and evaluates it. After enough consecutive matches it promotes itself to normal-power operation and pulses a transition event.
- **Normal-power** samples back to back until a programmed number of consecutive matches debounces the condition. It then pulses a match event and parks.

A 5-bit debug output shows the current state in a fixed encoding.

Top module: `adc_pair_sequencer`

## Requirements
- R1: After `rst_n` is low at a clock edge, `dbg_state` is 0x00, `adc_pd` is 1, `adc_chsel` is 00, both channel values are 0 and all three event outputs are 0.
- R2: Whenever `enable` is 0 at a clock edge, the next state is power-down (0x00) with `adc_pd` at 1.
- R3: While `soft_rst` is 1, the sequencer is held in power-down (0x00) with its counters cleared and both channel values at 0. On release with `enable` at 1, it enters power-up (0x01) on the next edge.
- R4: On leaving power-down, the state is 0x01 with `adc_pd` at 0 for exactly `pwrup_cycles`+1 cycles. The low-power re-wake state 0x0B lasts the same length.
- R5: Channel sequencing works as follows:
  - In a channel-0 state (0x02, 0x06, 0x0C), `adc_chsel` is 01 until `adc_valid` arrives. The strobe copies `adc_data` into `ch0_value`.
  - A gap state (0x03, 0x07, 0x0D) with `adc_chsel` at 00 then lasts exactly one cycle.
  - In a channel-1 state (0x04, 0x08, 0x0E), `adc_chsel` is 10 until a strobe copies `adc_data` into `ch1_value`.
  - A strobe in any other state changes neither value.
- R6: When `oneshot_mode` is 1, power-up leads to 0x02, 0x03, 0x04 and then 0x05, whatever `filt_all_match` shows. On entering 0x05, `ev_oneshot` is high for one cycle. The block stays in 0x05 with `adc_pd` at 1 until disabled.
- R7: In low-power flow, each pair ends in the one-cycle evaluate state 0x09. Unless promoted, the block then sleeps in 0x0A with `adc_pd` at 1 for max(`wake_period`,1) cycles, passes through 0x0B, and returns to 0x06.
- R8: A matching low-power pair raises the consecutive low-power count. A non-matching pair clears it. When the count reaches `lp_need` (0 behaves as 1), the next state is 0x0C and `ev_trans` is high for one cycle on entry.
- R9: Each normal-power pair ends in the one-cycle evaluate state 0x0F.
  - A match raises the consecutive normal-power count. Reaching `np_need` (0 behaves as 1) moves to 0x10, where `ev_match` is high for one cycle and `adc_pd` stays 1 until disabled.
  - Otherwise a match returns to 0x0C.
  - A mismatch clears the count. It then goes to 0x0A if `lp_mode` is 1, or to 0x0C if not.
- R10: With `oneshot_mode` 0, power-up leads to 0x06 when `lp_mode` is 1 and directly to 0x0C when it is 0.
- R11: `adc_pd` is 1 exactly in states 0x00, 0x05, 0x0A and 0x10. `adc_chsel` is 00 in every state except the channel states of R5. At most one event output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run request; 0 powers down and returns to idle |
| oneshot_mode | input | 1 | Selects the single-pair flow |
| lp_mode | input | 1 | Puts low-power sampling ahead of normal-power sampling |
| soft_rst | input | 1 | Synchronous hold of all sequencing state while 1 |
| pwrup_cycles | input | 4 | Converter warm-up time in clock cycles |
| wake_period | input | 24 | Sleep length between low-power samples |
| lp_need | input | 8 | Consecutive low-power matches needed for promotion |
| np_need | input | 16 | Consecutive normal-power matches needed for debounce |
| adc_valid | input | 1 | Converter result strobe |
| adc_data | input | 10 | Converter result |
| filt_all_match | input | 1 | Filter verdict for the pair, taken with the channel-1 strobe |
| adc_pd | output | 1 | Converter power-down request |
| adc_chsel | output | 2 | One-hot channel select (bit 0 channel 0, bit 1 channel 1) |
| dbg_state | output | 5 | Current state code |
| ch0_value | output | 10 | Last channel-0 result |
| ch1_value | output | 10 | Last channel-1 result |
| ev_oneshot | output | 1 | One-cycle pulse on oneshot completion |
| ev_trans | output | 1 | One-cycle pulse on promotion from low to normal power |
| ev_match | output | 1 | One-cycle pulse on debounced normal-power match |

## Verification
The sequencer is driven by a responder model of the converter that answers each channel select after a random latency. A per-pair script supplies the match verdicts.

- All-match scripts with random warm-up, wake and count settings confirm that the visits to each state and the sleep and warm-up lengths scale with the programmed values, including a zero wake period.
- Scripts with a single mismatch placed in low-power flow and in normal-power flow show whether the consecutive counters really restart. They also show where each flow goes afterwards.
- Oneshot runs with the verdict forced high and then low show that the verdict is ignored.
- A soft reset asserted during sleep checks that sequencing stops and that restart is clean.

// File: rtl/adcseq_pkg.sv
// Package: shared state encoding for the ADC pair sequencer.
// The numeric codes are visible on the debug port and must not change.
package adcseq_pkg;

    typedef enum logic [4:0] {
        ST_IDLE    = 5'h00,
        ST_WARM    = 5'h01,
        ST_OS_A    = 5'h02,
        ST_OS_GAP  = 5'h03,
        ST_OS_B    = 5'h04,
        ST_OS_END  = 5'h05,
        ST_LP_A    = 5'h06,
        ST_LP_GAP  = 5'h07,
        ST_LP_B    = 5'h08,
        ST_LP_CHK  = 5'h09,
        ST_LP_NAP  = 5'h0A,
        ST_LP_WARM = 5'h0B,
        ST_NP_A    = 5'h0C,
        ST_NP_GAP  = 5'h0D,
        ST_NP_B    = 5'h0E,
        ST_NP_CHK  = 5'h0F,
        ST_NP_END  = 5'h10
    } seq_state_e;

    localparam int unsigned NUM_CH = 2;

endpackage

// File: rtl/adcseq_counter.sv
// Module: adcseq_counter
// Up-counter with a synchronous clear that has priority over increment.
// Assumes the owner clears it before it can reach all-ones.
module adcseq_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    // Count register: reset, clear, or step by one.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + W'(1);
    end

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |-> (cnt != {W{1'b1}}));  // R8

endmodule

// File: rtl/adcseq_capture.sv
// Module: adcseq_capture
// Holds the last converter result for each channel.
// A result is taken when the strobe coincides with that channel's select bit.
// Assumes sel is one-hot or zero.
module adcseq_capture #(
    parameter int unsigned DW  = 10,
    parameter int unsigned NCH = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    valid,
    input  logic [NCH-1:0]          sel,
    input  logic [DW-1:0]           din,
    output logic [NCH-1:0][DW-1:0]  vals
);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        // Per-channel result holding register.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)          vals[ch] <= '0;
            else if (valid && sel[ch])  vals[ch] <= din;
        end
    end

    AST_CAP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (vals == '0));  // R3
    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !clr) |=> $stable(vals));  // R5

endmodule

// File: rtl/adc_pair_sequencer.sv
// Module: adc_pair_sequencer
// Power and channel sequencer for a two-channel converter.
// Flows: oneshot, low-power periodic wake with promotion, normal-power debounce.
// Assumes adc_valid is a single-cycle strobe answering the current select,
// and that filt_all_match is valid together with the channel-1 strobe.
module adc_pair_sequencer
    import adcseq_pkg::*;
#(
    parameter int unsigned DW     = 10,
    parameter int unsigned PWR_W  = 4,
    parameter int unsigned WAKE_W = 24,
    parameter int unsigned LPC_W  = 8,
    parameter int unsigned NPC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              oneshot_mode,
    input  logic              lp_mode,
    input  logic              soft_rst,
    input  logic [PWR_W-1:0]  pwrup_cycles,
    input  logic [WAKE_W-1:0] wake_period,
    input  logic [LPC_W-1:0]  lp_need,
    input  logic [NPC_W-1:0]  np_need,
    input  logic              adc_valid,
    input  logic [DW-1:0]     adc_data,
    input  logic              filt_all_match,
    output logic              adc_pd,
    output logic [1:0]        adc_chsel,
    output logic [4:0]        dbg_state,
    output logic [DW-1:0]     ch0_value,
    output logic [DW-1:0]     ch1_value,
    output logic              ev_oneshot,
    output logic              ev_trans,
    output logic              ev_match
);

    localparam int unsigned TMR_W = (WAKE_W > PWR_W) ? WAKE_W : PWR_W;

    seq_state_e state, nxt;
    logic hold;
    logic pair_match;
    logic [TMR_W-1:0] tmr;
    logic [LPC_W-1:0] lp_cnt;
    logic [NPC_W-1:0] np_cnt;
    logic tmr_clr, tmr_inc, lp_clr, lp_inc, np_clr, np_inc;
    logic pwr_done, nap_done, lp_hit, np_hit;
    logic [NUM_CH-1:0][DW-1:0] ch_vals;

    assign hold     = soft_rst || !enable;
    assign pwr_done = (tmr >= TMR_W'(pwrup_cycles));
    assign nap_done = (({1'b0, tmr} + (TMR_W+1)'(1)) >= {1'b0, TMR_W'(wake_period)});
    assign lp_hit   = (({1'b0, lp_cnt} + (LPC_W+1)'(1)) >= {1'b0, lp_need});
    assign np_hit   = (({1'b0, np_cnt} + (NPC_W+1)'(1)) >= {1'b0, np_need});

    // Next-state selection for all three flows.
    always_comb begin
        nxt = state;
        if (hold) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:    nxt = ST_WARM;
                ST_WARM:    if (pwr_done) nxt = oneshot_mode ? ST_OS_A :
                                               (lp_mode ? ST_LP_A : ST_NP_A);
                ST_OS_A:    if (adc_valid) nxt = ST_OS_GAP;
                ST_OS_GAP:  nxt = ST_OS_B;
                ST_OS_B:    if (adc_valid) nxt = ST_OS_END;
                ST_OS_END:  nxt = ST_OS_END;
                ST_LP_A:    if (adc_valid) nxt = ST_LP_GAP;
                ST_LP_GAP:  nxt = ST_LP_B;
                ST_LP_B:    if (adc_valid) nxt = ST_LP_CHK;
                ST_LP_CHK:  nxt = (pair_match && lp_hit) ? ST_NP_A : ST_LP_NAP;
                ST_LP_NAP:  if (nap_done) nxt = ST_LP_WARM;
                ST_LP_WARM: if (pwr_done) nxt = ST_LP_A;
                ST_NP_A:    if (adc_valid) nxt = ST_NP_GAP;
                ST_NP_GAP:  nxt = ST_NP_B;
                ST_NP_B:    if (adc_valid) nxt = ST_NP_CHK;
                ST_NP_CHK:  if (pair_match) nxt = np_hit ? ST_NP_END : ST_NP_A;
                            else            nxt = lp_mode ? ST_LP_NAP : ST_NP_A;
                ST_NP_END:  nxt = ST_NP_END;
                default:    nxt = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Pair verdict, taken with the channel-1 strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || hold)
            pair_match <= 1'b0;
        else if (adc_valid && (state == ST_OS_B || state == ST_LP_B || state == ST_NP_B))
            pair_match <= filt_all_match;
    end

    // Registered one-cycle event pulses, aligned with entry to the new state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_oneshot <= 1'b0;
            ev_trans   <= 1'b0;
            ev_match   <= 1'b0;
        end else begin
            ev_oneshot <= (nxt == ST_OS_END) && (state != ST_OS_END);
            ev_trans   <= (state == ST_LP_CHK) && (nxt == ST_NP_A);
            ev_match   <= (nxt == ST_NP_END) && (state != ST_NP_END);
        end
    end

    // Counter controls: one shared timer, two consecutive-match counters.
    always_comb begin
        tmr_inc = (state == ST_WARM) || (state == ST_LP_WARM) || (state == ST_LP_NAP);
        tmr_clr = hold || (nxt != state);
        lp_inc  = (state == ST_LP_CHK) && pair_match && !lp_hit;
        lp_clr  = hold || ((state == ST_LP_CHK) && !(pair_match && !lp_hit))
                       || ((state == ST_NP_CHK) && !pair_match);
        np_inc  = (state == ST_NP_CHK) && pair_match && !np_hit;
        np_clr  = hold || (state == ST_LP_CHK)
                       || ((state == ST_NP_CHK) && !(pair_match && !np_hit));
    end

    adcseq_counter #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .inc(tmr_inc), .cnt(tmr));
    adcseq_counter #(.W(LPC_W)) u_lpcnt (
        .clk(clk), .rst_n(rst_n), .clr(lp_clr), .inc(lp_inc), .cnt(lp_cnt));
    adcseq_counter #(.W(NPC_W)) u_npcnt (
        .clk(clk), .rst_n(rst_n), .clr(np_clr), .inc(np_inc), .cnt(np_cnt));

    adcseq_capture #(.DW(DW), .NCH(NUM_CH)) u_cap (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst), .valid(adc_valid),
        .sel(adc_chsel), .din(adc_data), .vals(ch_vals));

    // Output decode from the state code.
    always_comb begin
        adc_pd = (state == ST_IDLE) || (state == ST_OS_END) ||
                 (state == ST_LP_NAP) || (state == ST_NP_END);
        unique case (state)
            ST_OS_A, ST_LP_A, ST_NP_A: adc_chsel = 2'b01;
            ST_OS_B, ST_LP_B, ST_NP_B: adc_chsel = 2'b10;
            default:                   adc_chsel = 2'b00;
        endcase
    end

    assign dbg_state = state;
    assign ch0_value = ch_vals[0];
    assign ch1_value = ch_vals[1];

    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (dbg_state == 5'h00 && adc_pd));  // R2
    AST_SRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (dbg_state == 5'h00 && ch0_value == '0 && ch1_value == '0));  // R3
    AST_CH0_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NP_A && adc_valid && !hold) |=> (state == ST_NP_GAP));  // R5
    AST_OS_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OS_END && !hold) |=> (state == ST_OS_END));  // R6
    AST_TRANS_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        ev_trans |-> (state == ST_NP_A && $past(state) == ST_LP_CHK));  // R8
    AST_EV_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_oneshot, ev_trans, ev_match}));  // R11
    AST_CHSEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(adc_chsel));  // R11

endmodule

// File: tb/adc_pair_sequencer_test.sv
// Bench: responder model of the converter, scripted filter verdicts,
// state-run monitor, directed and seeded-random runs.
module adc_pair_sequencer_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, oneshot_mode = 1'b0, lp_mode = 1'b0, soft_rst = 1'b0;
    logic [3:0]  pwrup_cycles = 4'd7;
    logic [23:0] wake_period = 24'd10;
    logic [7:0]  lp_need = 8'd1;
    logic [15:0] np_need = 16'd1;
    logic        adc_valid, filt_all_match;
    logic [9:0]  adc_data;
    logic        adc_pd, ev_oneshot, ev_trans, ev_match;
    logic [1:0]  adc_chsel;
    logic [4:0]  dbg_state;
    logic [9:0]  ch0_value, ch1_value;

    adc_pair_sequencer uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .oneshot_mode(oneshot_mode),
        .lp_mode(lp_mode), .soft_rst(soft_rst), .pwrup_cycles(pwrup_cycles),
        .wake_period(wake_period), .lp_need(lp_need), .np_need(np_need),
        .adc_valid(adc_valid), .adc_data(adc_data), .filt_all_match(filt_all_match),
        .adc_pd(adc_pd), .adc_chsel(adc_chsel), .dbg_state(dbg_state),
        .ch0_value(ch0_value), .ch1_value(ch1_value), .ev_oneshot(ev_oneshot),
        .ev_trans(ev_trans), .ev_match(ev_match));

    always #10 clk = ~clk;

    int nchk = 0, nbad = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_warm(input int p);
        return p + 1;
    endfunction
    function automatic int exp_nap(input int w);
        return (w == 0) ? 1 : w;
    endfunction
    function automatic bit exp_pd(input int s);
        return (s == 0) || (s == 5) || (s == 10) || (s == 16);
    endfunction
    function automatic int exp_sel(input int s);
        if (s == 2 || s == 6 || s == 12) return 1;
        if (s == 4 || s == 8 || s == 14) return 2;
        return 0;
    endfunction

    // ---------------- converter responder ----------------
    bit script [0:15];
    int pair_idx = 0;
    int last_d0 = 0, last_d1 = 0;
    initial begin
        int lat, lat_cnt;
        lat = 0; lat_cnt = 0;
        adc_valid = 1'b0; adc_data = '0; filt_all_match = 1'b0;
        forever begin
            @(negedge clk);
            if (adc_valid) begin
                adc_valid = 1'b0;
                filt_all_match = 1'b0;
            end else if (adc_chsel != 2'b00) begin
                if (lat_cnt >= lat) begin
                    adc_valid = 1'b1;
                    adc_data = 10'($urandom % 1024);
                    if (adc_chsel == 2'b01) last_d0 = int'(adc_data);
                    else begin
                        last_d1 = int'(adc_data);
                        filt_all_match = script[pair_idx & 15];
                        pair_idx++;
                    end
                    lat = int'($urandom % 4);
                    lat_cnt = 0;
                end else lat_cnt++;
            end
        end
    end

    // ---------------- monitor (mid-high phase) ----------------
    int run_len [0:31];
    int visits  [0:31];
    int trans_cnt [0:31][0:31];
    int n_os = 0, n_tr = 0, n_mt = 0, mon_bad = 0;
    int prev_s = 0, cur_len = 0;
    bit mon_on = 1'b0;
    bit p_os = 0, p_tr = 0, p_mt = 0;

    task automatic mon_clear();
        for (int i = 0; i < 32; i++) begin
            run_len[i] = 0; visits[i] = 0;
            for (int j = 0; j < 32; j++) trans_cnt[i][j] = 0;
        end
        n_os = 0; n_tr = 0; n_mt = 0;
        prev_s = int'(dbg_state); cur_len = 1;
    endtask

    initial begin
        forever begin
            @(posedge clk); #5;
            if (mon_on) begin
                int s;
                s = int'(dbg_state);
                if (s == prev_s) cur_len++;
                else begin
                    run_len[prev_s] = cur_len;
                    trans_cnt[prev_s][s]++;
                    visits[s]++;
                    cur_len = 1;
                    prev_s = s;
                end
                if (adc_pd !== exp_pd(s) || int'(adc_chsel) != exp_sel(s)) mon_bad++;
                if ((ev_oneshot && p_os) || (ev_trans && p_tr) || (ev_match && p_mt)) mon_bad++;
                if (int'(ev_oneshot) + int'(ev_trans) + int'(ev_match) > 1) mon_bad++;
                if (ev_oneshot) n_os++;
                if (ev_trans) n_tr++;
                if (ev_match) n_mt++;
                p_os = ev_oneshot; p_tr = ev_trans; p_mt = ev_match;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic wait_state(input int target, input int limit, input string req);
        int n = 0;
        while (int'(dbg_state) != target && n < limit) begin
            @(negedge clk); n++;
        end
        chk(int'(dbg_state) == target, req, int'(dbg_state), target);
    endtask

    task automatic start_run(input bit os, input bit lp, input int p, input int w,
                             input int ln, input int nn);
        enable = 1'b0;
        repeat (2) @(negedge clk);
        oneshot_mode = os; lp_mode = lp;
        pwrup_cycles = 4'(p); wake_period = 24'(w);
        lp_need = 8'(ln); np_need = 16'(nn);
        pair_idx = 0;
        #6;
        mon_clear();
        @(negedge clk);
        enable = 1'b1;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            nchk++; nbad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        int seed, p, w, ln, nn;
        seed = int'($urandom(32'h5EED_0A1C));
        for (int i = 0; i < 16; i++) script[i] = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(dbg_state == 5'h00, "R1 state", int'(dbg_state), 0);
        chk(adc_pd == 1'b1 && adc_chsel == 2'b00, "R1 pd/sel", int'({adc_pd, adc_chsel}), 4);
        chk(ch0_value == 0 && ch1_value == 0, "R1 values", int'(ch0_value), 0);
        chk(!ev_oneshot && !ev_trans && !ev_match, "R1 events", int'(ev_match), 0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;

        // R6/R4/R5: oneshot, verdict high then low
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 16; i++) script[i] = (k == 0);
            p = int'($urandom % 16);
            start_run(1'b1, 1'b0, p, 5, 1, 1);
            wait_state(5, 500, "R6 reach done");
            chk(run_len[1] == exp_warm(p), "R4 warm length", run_len[1], exp_warm(p));
            chk(trans_cnt[1][2] == 1, "R6 warm->os ch0", trans_cnt[1][2], 1);
            chk(run_len[3] == 1, "R5 gap length", run_len[3], 1);
            chk(int'(ch0_value) == last_d0, "R5 ch0 value", int'(ch0_value), last_d0);
            chk(int'(ch1_value) == last_d1, "R5 ch1 value", int'(ch1_value), last_d1);
            repeat (20) @(negedge clk);
            chk(dbg_state == 5'h05 && adc_pd, "R6 park", int'(dbg_state), 5);
            chk(n_os == 1, "R6 one pulse", n_os, 1);
            // R2: disable drops to power-down on the next edge
            enable = 1'b0;
            @(negedge clk);
            chk(dbg_state == 5'h00 && adc_pd, "R2 disable", int'(dbg_state), 0);
        end

        // R10/R9: normal-power only, all match
        for (int i = 0; i < 16; i++) script[i] = 1'b1;
        start_run(1'b0, 1'b0, 3, 5, 1, 3);
        wait_state(16, 2000, "R9 reach end");
        chk(trans_cnt[1][12] == 1, "R10 warm->np", trans_cnt[1][12], 1);
        chk(visits[12] == 3, "R9 np pairs", visits[12], 3);
        chk(n_mt == 1 && n_tr == 0, "R9 match pulse", n_mt * 10 + n_tr, 10);
        repeat (10) @(negedge clk);
        chk(dbg_state == 5'h10 && adc_pd, "R9 park", int'(dbg_state), 16);

        // R9: mismatch restarts debounce without low-power
        script[0] = 1; script[1] = 1; script[2] = 0;
        script[3] = 1; script[4] = 1; script[5] = 1;
        start_run(1'b0, 1'b0, 2, 5, 1, 3);
        wait_state(16, 3000, "R9 reach end after miss");
        chk(visits[12] == 6, "R9 restart count", visits[12], 6);
        chk(trans_cnt[15][12] == 5, "R9 chk->np", trans_cnt[15][12], 5);

        // R7/R8: low-power with one miss, then promotion
        for (int i = 0; i < 16; i++) script[i] = 1'b1;
        script[0] = 1'b0;
        w = 2 + int'($urandom % 39);
        p = int'($urandom % 16);
        start_run(1'b0, 1'b1, p, w, 2, 2);
        wait_state(16, 4000, "R8 reach end");
        chk(visits[6] == 3, "R8 lp pairs", visits[6], 3);
        chk(visits[10] == 2, "R7 naps", visits[10], 2);
        chk(run_len[10] == exp_nap(w), "R7 nap length", run_len[10], exp_nap(w));
        chk(run_len[11] == exp_warm(p), "R4 rewake length", run_len[11], exp_warm(p));
        chk(run_len[9] == 1, "R7 eval length", run_len[9], 1);
        chk(n_tr == 1 && visits[12] == 2, "R8 promotion", n_tr, 1);

        // R9: normal-power miss returns to sleep when low-power is on
        script[0] = 1; script[1] = 0; script[2] = 1; script[3] = 1; script[4] = 1;
        start_run(1'b0, 1'b1, 1, 4, 1, 2);
        wait_state(16, 4000, "R9 reach end via sleep");
        chk(trans_cnt[15][10] == 1, "R9 chk->nap", trans_cnt[15][10], 1);
        chk(n_tr == 2, "R8 second promotion", n_tr, 2);
        chk(visits[12] == 3, "R9 np pairs after nap", visits[12], 3);

        // R3: soft reset during sleep
        for (int i = 0; i < 16; i++) script[i] = 1'b0;
        start_run(1'b0, 1'b1, 1, 1000, 3, 3);
        wait_state(10, 500, "R3 reach nap");
        soft_rst = 1'b1;
        @(negedge clk);
        chk(dbg_state == 5'h00 && adc_pd, "R3 held idle", int'(dbg_state), 0);
        chk(ch0_value == 0 && ch1_value == 0, "R3 values cleared", int'(ch1_value), 0);
        repeat (5) @(negedge clk);
        chk(dbg_state == 5'h00, "R3 still idle", int'(dbg_state), 0);
        soft_rst = 1'b0;
        @(negedge clk);
        chk(dbg_state == 5'h01, "R3 restart", int'(dbg_state), 1);

        // R7/R8/R9: seeded random all-match runs
        for (int i = 0; i < 16; i++) script[i] = 1'b1;
        for (int it = 0; it < 8; it++) begin
            p  = int'($urandom % 16);
            w  = (it == 0) ? 0 : int'($urandom % 31);
            ln = 1 + int'($urandom % 3);
            nn = 1 + int'($urandom % 3);
            start_run(1'b0, 1'b1, p, w, ln, nn);
            wait_state(16, 3000, "R9 random end");
            chk(run_len[1] == exp_warm(p), "R4 random warm", run_len[1], exp_warm(p));
            chk(visits[6] == ln, "R8 random lp pairs", visits[6], ln);
            chk(visits[10] == ln - 1, "R7 random naps", visits[10], ln - 1);
            if (ln > 1)
                chk(run_len[10] == exp_nap(w), "R7 random nap length", run_len[10], exp_nap(w));
            chk(visits[12] == nn, "R9 random np pairs", visits[12], nn);
            chk(n_tr == 1 && n_mt == 1, "R8 random events", n_tr + n_mt, 2);
        end

        enable = 1'b0;
        repeat (3) @(negedge clk);
        // R11: per-state power, select and event rules seen by the monitor
        chk(mon_bad == 0, "R11 decode/events", mon_bad, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

endmodule